// File: doc/BRIEF.md
# Dual Converter DMA Result Packer

This block sits between two sampling converters, one acting as master and one as slave, and a DMA engine. It captures each converter's result on its end-of-conversion strobe and raises DMA requests under a 2-bit mode field. In separate mode, each converter has its own request line and its own 16-bit data register. In packed mode, the block waits until both converters have delivered a result, in either order. It then raises a single request and presents one 32-bit word that carries both results.

Each captured result is right-aligned and zero-extended from the configured resolution. A per-converter pending flag records an unread result. A second end-of-conversion that lands on a still-pending result sets a sticky overrun flag for that converter, and the newer value replaces the older one. Packing is allowed in interleaved operation at any resolution. In simultaneous operation it is allowed only at 12-bit and 10-bit resolution. When packing is not allowed, the block behaves as in separate mode.

Top module: `dual_result_packer`

## Requirements
- R1: With mode_i = 2'b00, a converter's end-of-conversion sets its request (mst_req_o or slv_req_o) from the next cycle, and that converter's data register shows the captured result. The request drops in the same cycle as that converter's read strobe and stays low until the next end-of-conversion.
- R2: mode_i values 2'b01 and 2'b11 behave exactly like 2'b00, and pk_req_o stays low whenever packing is not in effect.
- R3: With packing in effect (mode_i = 2'b10), pk_req_o rises the cycle after the later of the two end-of-conversion events, whichever converter came first. mst_req_o and slv_req_o stay low throughout.
- R4: The packed word pk_dr_o holds the slave result in bits [31:16] and the master result in bits [15:0].
- R5: res_sel_i selects the result width: 2'b00 is 12 bits, 2'b01 is 10 bits, 2'b10 is 8 bits and 2'b11 is 6 bits. A captured result keeps its low bits of that width and has every higher bit cleared.
- R6: With packing in effect, pk_rd_i or dma_ack_i drops pk_req_o in the same cycle and clears both pending flags. A new packed request needs a fresh result from each converter.
- R7: End-of-conversion from both converters in the same cycle sets both pending flags, and pk_req_o asserts on the next cycle.
- R8: An end-of-conversion on a converter whose result is still pending, with no clearing read in that cycle, sets that converter's sticky overrun flag from the next cycle. The new result replaces the old one.
- R9: Packing is in effect for mode_i = 2'b10 when simul_i = 0, or when simul_i = 1 and res_sel_i is 2'b00 or 2'b01. Otherwise the block behaves as in R1.
- R10: After reset, all requests, data registers and overrun flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Request mode: 00 separate, 10 packed, 01/11 as 00 |
| res_sel_i | input | 2 | Resolution: 00=12, 01=10, 10=8, 11=6 bits |
| simul_i | input | 1 | 1 = simultaneous operation, 0 = interleaved |
| mst_eoc_i | input | 1 | Master end-of-conversion strobe |
| mst_data_i | input | 16 | Master result, right-aligned |
| slv_eoc_i | input | 1 | Slave end-of-conversion strobe |
| slv_data_i | input | 16 | Slave result, right-aligned |
| mst_rd_i | input | 1 | Read of master data register (separate mode) |
| slv_rd_i | input | 1 | Read of slave data register (separate mode) |
| pk_rd_i | input | 1 | Read of packed data register |
| dma_ack_i | input | 1 | DMA acknowledge of the packed request |
| mst_req_o | output | 1 | Master DMA request |
| slv_req_o | output | 1 | Slave DMA request |
| pk_req_o | output | 1 | Packed DMA request |
| mst_dr_o | output | 16 | Master data register |
| slv_dr_o | output | 16 | Slave data register |
| pk_dr_o | output | 32 | Packed word {slave, master} |
| mst_ovr_o | output | 1 | Master overrun flag, sticky |
| slv_ovr_o | output | 1 | Slave overrun flag, sticky |

## Verification
Data registers, pending flags and overrun flags are registered. Their effect therefore appears on the outputs one cycle after the clock edge that sees an end-of-conversion. Requests are a combinational function of the pending flags and the current read strobes, so a read or acknowledge drops a request in its own cycle. The bench drives every input at the falling edge and compares all outputs 1 ns later, against a bench model whose state is advanced once per cycle. Each comparison therefore sees the same-cycle request drop and the one-cycle-late capture at the right time.

// File: rtl/dpk_pkg.sv
package dpk_pkg;
  localparam int unsigned HW_W = 16;

  typedef enum logic [1:0] {
    MODE_SEP  = 2'b00,
    MODE_RSV1 = 2'b01,
    MODE_PACK = 2'b10,
    MODE_RSV3 = 2'b11
  } dpk_mode_e;

  typedef enum logic [1:0] {
    RES_12 = 2'b00,
    RES_10 = 2'b01,
    RES_8  = 2'b10,
    RES_6  = 2'b11
  } dpk_res_e;

  // low-bit mask for the selected resolution (12 - 2*sel bits)
  function automatic logic [HW_W-1:0] res_mask(input logic [1:0] sel);
    int unsigned w;
    w = 12 - 2 * int'(sel);
    return HW_W'((32'd1 << w) - 32'd1);
  endfunction
endpackage

// File: rtl/dpk_cfg.sv
module dpk_cfg
  import dpk_pkg::*;
#(
  parameter int unsigned W = HW_W
) (
  input  logic [1:0]   mode_i,
  input  logic [1:0]   res_sel_i,
  input  logic         simul_i,
  output logic         pack_en_o,
  output logic [W-1:0] mask_o
);
  logic res_ok;

  assign res_ok    = (res_sel_i == RES_12) || (res_sel_i == RES_10);
  assign pack_en_o = (dpk_mode_e'(mode_i) == MODE_PACK) && (!simul_i || res_ok);
  assign mask_o    = W'(res_mask(res_sel_i));
endmodule

// File: rtl/dpk_chan.sv
module dpk_chan #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         eoc_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  output logic         pend_o,
  output logic         ovr_o,
  output logic [W-1:0] data_o
);
  logic         pend_q, ovr_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
      data_q <= '0;
    end else if (eoc_i) begin
      data_q <= data_i & mask_i;
      pend_q <= 1'b1;
      if (pend_q && !clr_i) ovr_q <= 1'b1;  // unread result overwritten
    end else if (clr_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign ovr_o  = ovr_q;
  assign data_o = data_q;

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i |=> pend_o); // R1
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_i && pend_o && !clr_i) |=> ovr_o); // R8
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> ovr_o); // R8
  AST_CLR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !eoc_i) |=> !pend_o); // R6
  AST_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i |=> ((data_o & ~$past(mask_i)) == '0)); // R5
endmodule

// File: rtl/dpk_req.sv
module dpk_req #(
  parameter int unsigned N_CH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pack_en_i,
  input  logic [N_CH-1:0] pend_i,
  input  logic [N_CH-1:0] rd_i,
  input  logic            pk_clr_i,
  output logic [N_CH-1:0] req_o,
  output logic            pk_req_o,
  output logic [N_CH-1:0] clr_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign req_o[c] = !pack_en_i && pend_i[c] && !rd_i[c];
    assign clr_o[c] = pack_en_i ? pk_clr_i : rd_i[c];
  end

  assign pk_req_o = pack_en_i && (&pend_i) && !pk_clr_i;

  AST_PK_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pk_req_o |-> (&pend_i)); // R3
  AST_SEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pack_en_i |-> (req_o == '0)); // R3
  AST_PK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pk_clr_i |-> !pk_req_o); // R6
  AST_NO_PK_SEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pack_en_i |-> !pk_req_o); // R2
endmodule

// File: rtl/dual_result_packer.sv
module dual_result_packer
  import dpk_pkg::*;
#(
  parameter int unsigned DW = HW_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_i,
  input  logic [1:0]      res_sel_i,
  input  logic            simul_i,
  input  logic            mst_eoc_i,
  input  logic [DW-1:0]   mst_data_i,
  input  logic            slv_eoc_i,
  input  logic [DW-1:0]   slv_data_i,
  input  logic            mst_rd_i,
  input  logic            slv_rd_i,
  input  logic            pk_rd_i,
  input  logic            dma_ack_i,
  output logic            mst_req_o,
  output logic            slv_req_o,
  output logic            pk_req_o,
  output logic [DW-1:0]   mst_dr_o,
  output logic [DW-1:0]   slv_dr_o,
  output logic [2*DW-1:0] pk_dr_o,
  output logic            mst_ovr_o,
  output logic            slv_ovr_o
);
  localparam int unsigned N_CH = 2;  // index 0 master, 1 slave

  logic              pack_en;
  logic [DW-1:0]     mask;
  logic [N_CH-1:0]   eoc, rd, pend, ovr, clr, req;
  logic [DW-1:0]     din  [N_CH];
  logic [DW-1:0]     dout [N_CH];

  assign eoc    = {slv_eoc_i, mst_eoc_i};
  assign rd     = {slv_rd_i, mst_rd_i};
  assign din[0] = mst_data_i;
  assign din[1] = slv_data_i;

  dpk_cfg #(.W(DW)) u_cfg (
    .mode_i    (mode_i),
    .res_sel_i (res_sel_i),
    .simul_i   (simul_i),
    .pack_en_o (pack_en),
    .mask_o    (mask)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    dpk_chan #(.W(DW)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .eoc_i  (eoc[c]),
      .data_i (din[c]),
      .mask_i (mask),
      .clr_i  (clr[c]),
      .pend_o (pend[c]),
      .ovr_o  (ovr[c]),
      .data_o (dout[c])
    );
  end

  dpk_req #(.N_CH(N_CH)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pack_en_i (pack_en),
    .pend_i    (pend),
    .rd_i      (rd),
    .pk_clr_i  (pk_rd_i | dma_ack_i),
    .req_o     (req),
    .pk_req_o  (pk_req_o),
    .clr_o     (clr)
  );

  assign mst_req_o = req[0];
  assign slv_req_o = req[1];
  assign mst_dr_o  = dout[0];
  assign slv_dr_o  = dout[1];
  assign pk_dr_o   = {dout[1], dout[0]};
  assign mst_ovr_o = ovr[0];
  assign slv_ovr_o = ovr[1];

  AST_PK_LAYOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pk_req_o |-> (pk_dr_o[DW-1:0] == mst_dr_o && pk_dr_o[2*DW-1:DW] == slv_dr_o)); // R4
  AST_PAIR_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pack_en && mst_eoc_i && slv_eoc_i) ##1 (pack_en && !pk_rd_i && !dma_ack_i)
      |-> pk_req_o); // R7
endmodule

// File: tb/dual_result_packer_tb_top.sv
module dual_result_packer_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  mode = 2'b00, res = 2'b00;
  logic        simul = 1'b0, meoc = 1'b0, seoc = 1'b0;
  logic [15:0] mdat = '0, sdat = '0;
  logic        mrd = 1'b0, srd = 1'b0, prd = 1'b0, ack = 1'b0;
  logic        mreq, sreq, preq, movr, sovr;
  logic [15:0] mdr, sdr;
  logic [31:0] pdr;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model state
  logic        m_pend [2];
  logic        m_ovr  [2];
  logic [15:0] m_dat  [2];

  always #5 clk = ~clk;

  dual_result_packer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .res_sel_i(res), .simul_i(simul),
    .mst_eoc_i(meoc), .mst_data_i(mdat), .slv_eoc_i(seoc), .slv_data_i(sdat),
    .mst_rd_i(mrd), .slv_rd_i(srd), .pk_rd_i(prd), .dma_ack_i(ack),
    .mst_req_o(mreq), .slv_req_o(sreq), .pk_req_o(preq),
    .mst_dr_o(mdr), .slv_dr_o(sdr), .pk_dr_o(pdr),
    .mst_ovr_o(movr), .slv_ovr_o(sovr)
  );

  function automatic logic [15:0] exp_mask(input logic [1:0] r);
    case (r)
      2'b00:   return 16'h0FFF;
      2'b01:   return 16'h03FF;
      2'b10:   return 16'h00FF;
      default: return 16'h003F;
    endcase
  endfunction

  function automatic logic exp_pack(input logic [1:0] md, input logic [1:0] r, input logic sm);
    return (md == 2'b10) && (!sm || r == 2'b00 || r == 2'b01);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_pend[c] = 1'b0; m_ovr[c] = 1'b0; m_dat[c] = '0;
    end
  endtask

  // drive one cycle, compare all outputs, advance model
  task automatic step(input logic [1:0] md, input logic [1:0] r, input logic sm,
                      input logic me, input logic [15:0] mv, input logic se, input logic [15:0] sv,
                      input logic mr, input logic sr, input logic pr, input logic ak,
                      input string tag);
    logic pe, pclr;
    logic eo [2];
    logic rdv [2];
    logic [15:0] dv [2];
    @(negedge clk);
    mode = md; res = r; simul = sm; meoc = me; mdat = mv; seoc = se; sdat = sv;
    mrd = mr; srd = sr; prd = pr; ack = ak;
    #1;
    pe   = exp_pack(md, r, sm);
    pclr = pr | ak;
    chk(tag, "mst_req", 32'(mreq), 32'(!pe && m_pend[0] && !mr));
    chk(tag, "slv_req", 32'(sreq), 32'(!pe && m_pend[1] && !sr));
    chk(tag, "pk_req",  32'(preq), 32'(pe && m_pend[0] && m_pend[1] && !pclr));
    chk(tag, "mst_dr",  32'(mdr),  32'(m_dat[0]));
    chk(tag, "slv_dr",  32'(sdr),  32'(m_dat[1]));
    chk(tag, "pk_dr",   pdr,       {m_dat[1], m_dat[0]});
    chk(tag, "ovr",     32'({sovr, movr}), 32'({m_ovr[1], m_ovr[0]}));
    eo[0] = me; eo[1] = se; dv[0] = mv; dv[1] = sv; rdv[0] = mr; rdv[1] = sr;
    for (int c = 0; c < 2; c++) begin
      logic cl;
      cl = pe ? pclr : rdv[c];
      if (eo[c]) begin
        m_dat[c] = dv[c] & exp_mask(r);
        if (m_pend[c] && !cl) m_ovr[c] = 1'b1;
        m_pend[c] = 1'b1;
      end else if (cl) begin
        m_pend[c] = 1'b0;
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input logic [1:0] md, input logic [1:0] r, input logic sm, input string tag);
    step(md, r, sm, 0, 16'h0, 0, 16'h0, 0, 0, 0, 0, tag);
  endtask

  task automatic rand_seg(input logic [1:0] md, input logic [1:0] r, input logic sm,
                          input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      logic pe;
      pe = exp_pack(md, r, sm);
      step(md, r, sm,
           ($urandom % 3) == 0, 16'($urandom), ($urandom % 3) == 0, 16'($urandom),
           !pe && ($urandom % 3) == 0, !pe && ($urandom % 3) == 0,
           pe && ($urandom % 5) == 0, pe && ($urandom % 5) == 0, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    idle(2'b00, 2'b00, 0, "R10");

    // R1: separate mode, read clears request same cycle
    step(2'b00, 2'b00, 0, 1, 16'h0ABC, 0, 16'h0, 0, 0, 0, 0, "R1");
    step(2'b00, 2'b00, 0, 0, 16'h0, 1, 16'h0123, 0, 0, 0, 0, "R1");
    step(2'b00, 2'b00, 0, 0, 16'h0, 0, 16'h0, 1, 0, 0, 0, "R1");
    step(2'b00, 2'b00, 0, 0, 16'h0, 0, 16'h0, 0, 1, 0, 0, "R1");
    idle(2'b00, 2'b00, 0, "R1");

    // R5: each resolution with all-ones input
    for (int r = 0; r < 4; r++) begin
      step(2'b00, 2'(r), 0, 1, 16'hFFFF, 1, 16'hFFFF, 0, 0, 0, 0, "R5");
      step(2'b00, 2'(r), 0, 0, 16'h0, 0, 16'h0, 1, 1, 0, 0, "R5");
    end

    // R3: slave first, then master; then read
    step(2'b10, 2'b00, 0, 0, 16'h0, 1, 16'h0555, 0, 0, 0, 0, "R3");
    idle(2'b10, 2'b00, 0, "R3");
    step(2'b10, 2'b00, 0, 1, 16'h0AAA, 0, 16'h0, 0, 0, 0, 0, "R3");
    idle(2'b10, 2'b00, 0, "R4");
    step(2'b10, 2'b00, 0, 0, 16'h0, 0, 16'h0, 0, 0, 1, 0, "R6");
    idle(2'b10, 2'b00, 0, "R6");

    // R7: both at once; R6: ack drops it; one fresh side is not enough
    step(2'b10, 2'b01, 1, 1, 16'h0321, 1, 16'h0234, 0, 0, 0, 0, "R7");
    idle(2'b10, 2'b01, 1, "R7");
    step(2'b10, 2'b01, 1, 1, 16'h0111, 0, 16'h0, 0, 0, 0, 1, "R6");
    idle(2'b10, 2'b01, 1, "R6");
    step(2'b10, 2'b01, 1, 0, 16'h0, 0, 16'h0, 0, 0, 1, 0, "R6");
    step(2'b10, 2'b01, 1, 1, 16'h0042, 0, 16'h0, 0, 0, 0, 0, "R6");
    idle(2'b10, 2'b01, 1, "R6");

    // R9: simultaneous at 8-bit falls back to separate
    step(2'b10, 2'b10, 1, 0, 16'h0, 1, 16'h00F0, 0, 0, 0, 0, "R9");
    idle(2'b10, 2'b10, 1, "R9");
    step(2'b10, 2'b10, 1, 0, 16'h0, 0, 16'h0, 0, 1, 0, 0, "R9");

    // R8: overrun on master, with replacement
    do_reset();
    step(2'b00, 2'b00, 0, 1, 16'h0100, 0, 16'h0, 0, 0, 0, 0, "R8");
    step(2'b00, 2'b00, 0, 1, 16'h0200, 0, 16'h0, 0, 0, 0, 0, "R8");
    idle(2'b00, 2'b00, 0, "R8");
    step(2'b00, 2'b00, 0, 0, 16'h0, 1, 16'h0300, 0, 1, 0, 0, "R8");
    idle(2'b00, 2'b00, 0, "R8");

    // random segments
    do_reset();
    for (int s = 0; s < 24; s++) begin
      logic [1:0] md, r;
      logic sm;
      string tg;
      md = 2'($urandom); r = 2'($urandom); sm = 1'($urandom);
      if (md == 2'b01 || md == 2'b11) tg = "R2";
      else if (md == 2'b10 && sm && r[1]) tg = "R9";
      else if (md == 2'b10) tg = "R3";
      else tg = "R1";
      rand_seg(md, r, sm, tg, 60);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule